// File: doc/BRIEF.md
# Key-Locked Fetch Instruction Buffer

This block is the in-order instruction queue that sits between instruction fetch and register rename. Fetch offers a group of up to four instruction slots per cycle, each with its own valid bit. Rename reads the oldest four entries and asks for up to four of them to be removed in the same cycle. When the offered group does not fit in the free entries, the block raises a stall towards fetch. Fetch then holds the group until the stall drops. Entries already held keep draining to rename while the stall is up.

On top of this space-based stall sits a performance lock. The four offered slots form one 80-bit word, with lane 0 in the low 20 bits. An accepted, fully valid group can equal the secret word given by the `SECRET` parameter. If the key input then differs from that same secret, the group is still stored, and fetch is shut out for the next `LOCK_CYCLES` cycles. With the matching key the lock never fires, so timing is the same as in a buffer without a lock. The depth must be a power of two and at least four.

Top module: `locked_fetch_buffer`

## Requirements
- R1: In a cycle without stall, every valid lane of the offered group is stored, and the stored lanes keep lane order with the invalid lanes squeezed out. Lane i occupies bits [20*i+19:20*i] of the group and of the output word.
- R2: `fetch_stall` is high whenever the number of valid offered lanes exceeds DEPTH minus the occupancy at the start of the cycle, and nothing from the group is stored in a stalled cycle.
- R3: Rename sees the oldest entries on `out_instr`, oldest in lane 0. `out_valid[i]` is high exactly when more than i entries are held. Each cycle removes min(pop_req, 4, occupancy) entries, so a request above four counts as four.
- R4: Entries keep leaving on rename requests while `fetch_stall` is high.
- R5: `fetch_stall` is low whenever the offered group fits in the free entries and no lock window is open.
- R6: Suppose an accepted group has all four lanes valid, equals `SECRET`, and arrives while `key` differs from `SECRET`. That group is stored, and `fetch_stall` is then high for exactly the following LOCK_CYCLES cycles, whatever the occupancy.
- R7: With `key` equal to `SECRET`, a group equal to `SECRET` opens no lock window, and the stall behaviour matches R2 and R5 alone.
- R8: A group whose lanes match `SECRET` but which has at least one invalid lane opens no lock window.
- R9: After reset the buffer is empty: `out_valid` is zero and `fetch_stall` is low for any group of up to four lanes.
- R10: Entries leave in the order they were stored, with none lost or repeated across stalls or lock windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Per-lane valid of the offered fetch group |
| in_instr | input | LANES*SLOT_W | Offered fetch group, lane 0 in the low bits |
| key | input | LANES*SLOT_W | Unlock key compared with `SECRET` |
| fetch_stall | output | 1 | Holds fetch; the offered group is not taken |
| pop_req | input | $clog2(LANES+1) | Number of entries rename removes this cycle |
| out_valid | output | LANES | Lane i of the output holds an entry |
| out_instr | output | LANES*SLOT_W | Oldest entries, oldest in lane 0 |

## Verification
The bench builds the buffer with DEPTH 8 and LOCK_CYCLES 5. With these values two full groups fill the buffer, so the stall on a full buffer and its release after partial drains take only a few cycles. The whole lock window, including the first cycle after it closes, also fits in a short directed test. `SECRET` keeps its default, and the bench drives the key both matching and inverted, so the lock and its bypass are both reached, as is the partial-valid near miss.

// File: rtl/locked_fetch_buffer.sv
module locked_fetch_buffer #(
  parameter int DEPTH       = 16,
  parameter int SLOT_W      = 20,
  parameter int LANES       = 4,
  parameter int LOCK_CYCLES = 1024,
  parameter logic [LANES*SLOT_W-1:0] SECRET = 80'h3A5C1_2B6D2_1C7E3_0D8F4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          in_valid,
  input  logic [LANES*SLOT_W-1:0]   in_instr,
  input  logic [LANES*SLOT_W-1:0]   key,
  output logic                      fetch_stall,
  input  logic [$clog2(LANES+1)-1:0] pop_req,
  output logic [LANES-1:0]          out_valid,
  output logic [LANES*SLOT_W-1:0]   out_instr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int LN_W  = $clog2(LANES+1);
  localparam int LK_W  = $clog2(LOCK_CYCLES+1);

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [LK_W-1:0]   lock_cnt;
  logic [LN_W-1:0]   off [LANES];
  logic [LN_W-1:0]   in_cnt, pop_lim, pop_cnt, wr_cnt;
  logic [CNT_W-1:0]  free;
  logic              space_stall, lock_busy, accept, trigger;

  always_comb begin
    in_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      off[i] = in_cnt;
      in_cnt = in_cnt + LN_W'(in_valid[i]);
    end
  end

  assign free        = CNT_W'(DEPTH) - count;
  assign space_stall = CNT_W'(in_cnt) > free;
  assign lock_busy   = lock_cnt != '0;
  assign fetch_stall = lock_busy | space_stall;
  assign accept      = ~fetch_stall;
  assign wr_cnt      = accept ? in_cnt : '0;
  assign trigger     = accept & (&in_valid) & (in_instr == SECRET) & (key != SECRET);
  assign pop_lim     = (pop_req > LN_W'(LANES)) ? LN_W'(LANES) : pop_req;
  assign pop_cnt     = (CNT_W'(pop_lim) > count) ? LN_W'(count) : pop_lim;

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < LANES; i++)
        if (in_valid[i]) mem[tail + PTR_W'(off[i])] <= in_instr[i*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      lock_cnt <= '0;
    end else begin
      tail  <= tail + PTR_W'(wr_cnt);
      head  <= head + PTR_W'(pop_cnt);
      count <= count + CNT_W'(wr_cnt) - CNT_W'(pop_cnt);
      if (trigger)        lock_cnt <= LK_W'(LOCK_CYCLES);
      else if (lock_busy) lock_cnt <= lock_cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign out_instr[g*SLOT_W +: SLOT_W] = mem[head + PTR_W'(g)];
    assign out_valid[g] = count > CNT_W'(g);
  end
endmodule

// File: rtl/locked_fetch_buffer_chk.sv
module locked_fetch_buffer_chk #(
  parameter int DEPTH       = 16,
  parameter int SLOT_W      = 20,
  parameter int LANES       = 4,
  parameter int LOCK_CYCLES = 1024,
  parameter logic [LANES*SLOT_W-1:0] SECRET = 80'h3A5C1_2B6D2_1C7E3_0D8F4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [LANES-1:0]           in_valid,
  input logic [LANES*SLOT_W-1:0]    in_instr,
  input logic [LANES*SLOT_W-1:0]    key,
  input logic                       fetch_stall,
  input logic [$clog2(LANES+1)-1:0] pop_req,
  input logic [LANES-1:0]           out_valid,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  int need, room, win;
  logic seen;

  assign need = $countones(in_valid);
  assign room = DEPTH - int'(count);
  assign seen = !fetch_stall && (&in_valid) && in_instr == SECRET && key != SECRET;

  always_ff @(posedge clk) begin
    if (!rst_n)       win <= 0;
    else if (seen)    win <= LOCK_CYCLES;
    else if (win > 0) win <= win - 1;
  end

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (need > room) |-> fetch_stall);
  a_r3_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & (out_valid + 1'b1)) == '0);
  a_r4_drain_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && pop_req != '0 && count != '0) |=> count < $past(count));
  a_r5_fits_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall |-> need <= room);
  a_r6_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win != 0) |-> fetch_stall);
  a_r7_no_spurious_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 0 && fetch_stall) |-> need > room);
endmodule

bind locked_fetch_buffer locked_fetch_buffer_chk #(
  .DEPTH(DEPTH), .SLOT_W(SLOT_W), .LANES(LANES),
  .LOCK_CYCLES(LOCK_CYCLES), .SECRET(SECRET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
  .key(key), .fetch_stall(fetch_stall), .pop_req(pop_req),
  .out_valid(out_valid), .count(count)
);

// File: tb/sim_locked_fetch_buffer.sv
module sim_locked_fetch_buffer;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int NLOCK  = 5;
  localparam logic [79:0] SECRET = 80'h3A5C1_2B6D2_1C7E3_0D8F4;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  in_valid = '0;
  logic [79:0] in_instr = '0, key = SECRET;
  logic [2:0]  pop_req = '0;
  logic        fetch_stall;
  logic [3:0]  out_valid;
  logic [79:0] out_instr;

  int checks = 0, fails = 0, lock_left = 0;
  bit done = 0;
  logic [19:0] q[$];
  logic [19:0] seq = 20'h00100;

  always #(PERIOD/2) clk = ~clk;

  locked_fetch_buffer #(.DEPTH(DEPTH), .LOCK_CYCLES(NLOCK), .SECRET(SECRET)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .key(key),
    .fetch_stall(fetch_stall), .pop_req(pop_req), .out_valid(out_valid), .out_instr(out_instr));

  task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] grp();
    logic [79:0] w;
    for (int i = 0; i < 4; i++) begin
      w[i*20 +: 20] = seq;
      seq = seq + 1;
    end
    return w;
  endfunction

  task automatic cyc(input logic [3:0] v, input logic [79:0] w, input logic [79:0] k,
                     input int pop, input string tag, output logic stalled);
    int need, eff;
    logic [3:0]  ev;
    logic [79:0] mask, ew;
    @(negedge clk);
    in_valid = v; in_instr = w; key = k; pop_req = 3'(pop);
    #1;
    need = $countones(v);
    stalled = (lock_left > 0) || (need > DEPTH - q.size());
    check({tag, " stall"}, {79'b0, fetch_stall}, {79'b0, stalled});
    ev = '0; ew = '0; mask = '0;
    for (int i = 0; i < 4; i++)
      if (i < q.size()) begin
        ev[i] = 1'b1; ew[i*20 +: 20] = q[i]; mask[i*20 +: 20] = '1;
      end
    check({tag, " R3 valid"}, {76'b0, out_valid}, {76'b0, ev});
    check({tag, " R10 order"}, out_instr & mask, ew);
    @(posedge clk);
    eff = (pop > 4) ? 4 : pop;
    if (eff > q.size()) eff = q.size();
    for (int i = 0; i < eff; i++) void'(q.pop_front());
    if (lock_left > 0) lock_left--;
    if (!stalled) begin
      for (int i = 0; i < 4; i++) if (v[i]) q.push_back(w[i*20 +: 20]);
      if (v == 4'hF && w == SECRET && k != SECRET) lock_left = NLOCK;
    end
  endtask

  task automatic drain();
    logic s;
    while (q.size() > 0) cyc(4'h0, '0, SECRET, 4, "R3", s);
    cyc(4'h0, '0, SECRET, 0, "R3", s);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_valid = 4'hF; #1;
    check("R9 stall after reset", {79'b0, fetch_stall}, 80'b0);
    check("R9 empty after reset", {76'b0, out_valid}, 80'b0);
    in_valid = '0;
    rst_n = 1;
  endtask

  task automatic t_fill();
    logic s;
    logic [79:0] g;
    cyc(4'hF, grp(), SECRET, 0, "R1", s);
    cyc(4'hF, grp(), SECRET, 0, "R1", s);
    g = grp();
    cyc(4'hF, g, SECRET, 0, "R2", s);
    check("R2 full buffer stalls", {79'b0, s}, 80'b1);
    cyc(4'hF, g, SECRET, 2, "R2 R4", s);
    cyc(4'hF, g, SECRET, 2, "R2 R4", s);
    check("R2 two free still stalls", {79'b0, s}, 80'b1);
    cyc(4'hF, g, SECRET, 0, "R5", s);
    check("R5 released when group fits", {79'b0, s}, 80'b0);
    cyc(4'h1, grp(), SECRET, 7, "R3", s);
    drain();
  endtask

  task automatic t_partial();
    logic s;
    cyc(4'b1010, grp(), SECRET, 0, "R1", s);
    cyc(4'b0101, grp(), SECRET, 0, "R1", s);
    cyc(4'b1000, grp(), SECRET, 1, "R1", s);
    drain();
  endtask

  task automatic t_lock_wrong();
    logic s;
    int n;
    cyc(4'hF, SECRET, ~SECRET, 0, "R6", s);
    check("R6 matching group taken", {79'b0, s}, 80'b0);
    n = 0;
    s = 1;
    while (s && n < 50) begin
      cyc(4'h1, {60'b0, 20'h7777}, ~SECRET, 1, "R6 R4", s);
      if (s) n++;
    end
    check("R6 lock window length", 80'(n), 80'(NLOCK));
    drain();
  endtask

  task automatic t_lock_right();
    logic s;
    cyc(4'hF, SECRET, SECRET, 0, "R7", s);
    cyc(4'h1, grp(), SECRET, 0, "R7", s);
    check("R7 correct key no lock", {79'b0, s}, 80'b0);
    drain();
  endtask

  task automatic t_partial_match();
    logic s;
    cyc(4'b0111, SECRET, ~SECRET, 0, "R8", s);
    cyc(4'h1, grp(), ~SECRET, 0, "R8", s);
    check("R8 partial match no lock", {79'b0, s}, 80'b0);
    drain();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_partial();
    t_lock_wrong();
    t_lock_right();
    t_partial_match();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule